// File: doc/BRIEF.md
# Remote Measurement Trigger Sequencer

This block lets an external controller run an instrument's measurements. A single active-low mode line picks local or remote operation. In local mode the four instrument function controls come from front-panel inputs. In remote mode they come from four ground-true remote lines. A low remote line reads as an asserted function bit.

In remote mode the block also raises a hold output. The hold stops the meters from sampling on their own, so a reading happens only when the controller asks for one. The controller asks by pulling an active-low measure strobe low. If the block is in remote mode and idle, it sets a data flag and starts a delay. The delay length is picked by a 2-bit code. When the delay ends, the block pulses a trigger to the meters. A fixed settle interval follows. Then the flag clears, which tells the controller the data is ready.

The flag feeds back into the request logic. One strobe, however short, therefore runs the whole sequence, and further strobes are ignored while the flag is up. A jumper-option input keeps the front-panel controls in charge while remote triggering stays available. All inputs are taken to be synchronous to `clk`. All pins are plain level or pulse signals with no handshake, so no back-pressure applies.

Top module: `rmt_meas_seq`

## Requirements
- R1: With `lr_sel_n` high (local), `fn_out` equals `panel_fn` one clock after it is sampled.
- R2: With `lr_sel_n` low (remote) and `keep_panel` low, `fn_out` equals the bitwise inverse of `remote_fn_n` one clock later. A low remote line gives a 1.
- R3: With `keep_panel` high, `fn_out` follows `panel_fn` in both modes, and `remote_fn_n` has no effect on it.
- R4: `meter_hold` is high one clock after `lr_sel_n` is sampled low and low one clock after it is sampled high. `keep_panel` has no effect on it.
- R5: A low `meas_n` sampled while `lr_sel_n` is high is ignored: the flag stays clear and `trig` stays low.
- R6: A low `meas_n` sampled in remote mode while idle sets the flag at that edge. While the flag is set, `flag_p_n` is low and `flag_m` is high, and the two are always complementary.
- R7: `trig` is a one-clock pulse. It rises N clocks after the flag sets. N is DLY0, DLY1, DLY2 or DLY3 for `dly_sel` codes 0, 1, 2 and 3, with `dly_sel` sampled when the strobe is accepted.
- R8: The flag clears SETTLE_CYC clocks after `trig` rises.
- R9: A strobe that lasts one clock still runs the full sequence.
- R10: A strobe that arrives while the flag is set is ignored. No extra trigger occurs and the flag clears at its original time.
- R11: During reset, `fn_out`=0, `meter_hold`=0, `trig`=0, `flag_p_n`=1 and `flag_m`=0.
- R12: With `keep_panel` high in remote mode, a strobe still runs the full delay, trigger and settle sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_sel_n | input | 1 | Mode select: low = remote, high = local |
| meas_n | input | 1 | Active-low measure strobe |
| keep_panel | input | 1 | Jumper option: keep the front-panel function controls |
| dly_sel | input | 2 | Delay code 0..3 |
| panel_fn | input | NFN | Front-panel function bits |
| remote_fn_n | input | NFN | Ground-true remote function lines |
| fn_out | output | NFN | Selected function bits |
| meter_hold | output | 1 | Stops the meters' internal sampling |
| trig | output | 1 | One-clock meter trigger pulse |
| flag_p_n | output | 1 | Data flag, low while a measurement is in progress |
| flag_m | output | 1 | Data flag complement, high while in progress |

## Verification
`fn_out` and `meter_hold` change one clock after their inputs are sampled. The flag changes at the same edge that accepts the strobe. `trig` rises N edges after that acceptance edge, and the flag falls SETTLE_CYC edges after `trig` rises. The bench drives and samples on falling edges. For each run it numbers the falling edges from the acceptance edge and records the index at which `trig` first rises and the index at which the flag falls. It then compares those indices with N and N+SETTLE_CYC. Where a requirement says a stimulus is ignored, the bench watches the flag and `trig` over a window longer than the longest sequence.

// File: rtl/rmt_seq_pkg.sv
package rmt_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SETTLE} seq_st_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rmt_func_mux.sv
module rmt_func_mux #(
  parameter int NFN = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           remote,
  input  logic           keep_panel,
  input  logic [NFN-1:0] panel_fn,
  input  logic [NFN-1:0] remote_fn_n,
  output logic [NFN-1:0] fn_out,
  output logic           meter_hold
);
  logic           use_rmt;
  logic [NFN-1:0] pick;

  assign use_rmt = remote & ~keep_panel;

  for (genvar i = 0; i < NFN; i++) begin : g_fn
    // ground-true remote line: low means asserted
    assign pick[i] = use_rmt ? ~remote_fn_n[i] : panel_fn[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fn_out     <= '0;
      meter_hold <= 1'b0;
    end else begin
      fn_out     <= pick;
      meter_hold <= remote;
    end
  end

  p_local_panel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !remote |=> fn_out == $past(panel_fn));
  p_remote_lines_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (remote && !keep_panel) |=> fn_out == ~$past(remote_fn_n));
  p_jumper_panel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    keep_panel |=> fn_out == $past(panel_fn));
  p_hold_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    remote |=> meter_hold);
  p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !remote |=> !meter_hold);
endmodule

// File: rtl/rmt_dly_ctr.sv
module rmt_dly_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (ld)        cnt <= ld_val;
    else if (cnt != '0) cnt <= cnt - CW'(1);
  end

  assign zero = (cnt == '0);

  p_load_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt == $past(ld_val));
  p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && cnt != '0) |=> cnt == $past(cnt) - CW'(1));
endmodule

// File: rtl/rmt_flag_seq.sv
module rmt_flag_seq
  import rmt_seq_pkg::*;
#(
  parameter int CW         = 8,
  parameter int SETTLE_LEN = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          remote,
  input  logic          meas_n,
  input  logic [CW-1:0] dly_len,
  input  logic          cnt_zero,
  output logic          ld,
  output logic [CW-1:0] ld_val,
  output logic          trig,
  output logic          flag
);
  seq_st_t state;
  logic    accept;

  // request is honoured only while idle: the set flag blocks new strobes
  assign accept = (state == ST_IDLE) && remote && !meas_n;

  always_comb begin
    ld     = 1'b0;
    ld_val = '0;
    if (accept) begin
      ld     = 1'b1;
      ld_val = dly_len - CW'(1);
    end else if (state == ST_WAIT && cnt_zero) begin
      ld     = 1'b1;
      ld_val = CW'(SETTLE_LEN - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      trig  <= 1'b0;
      flag  <= 1'b0;
    end else begin
      trig <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          state <= ST_WAIT;
          flag  <= 1'b1;
        end
        ST_WAIT: if (cnt_zero) begin
          state <= ST_SETTLE;
          trig  <= 1'b1;
        end
        ST_SETTLE: if (cnt_zero) begin
          state <= ST_IDLE;
          flag  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_local_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !remote) |=> !flag);
  p_flag_on_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && remote && !meas_n) |=> flag);
  p_trig_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);
  p_trig_inside_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> flag);
  p_flag_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && state != ST_SETTLE) |=> flag);
  p_busy_no_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !cnt_zero) |=> state == ST_WAIT);
endmodule

// File: rtl/rmt_meas_seq.sv
module rmt_meas_seq
  import rmt_seq_pkg::*;
#(
  parameter int NFN        = 4,
  parameter int DLY0       = 3,
  parameter int DLY1       = 6,
  parameter int DLY2       = 10,
  parameter int DLY3       = 20,
  parameter int SETTLE_CYC = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           lr_sel_n,
  input  logic           meas_n,
  input  logic           keep_panel,
  input  logic [1:0]     dly_sel,
  input  logic [NFN-1:0] panel_fn,
  input  logic [NFN-1:0] remote_fn_n,
  output logic [NFN-1:0] fn_out,
  output logic           meter_hold,
  output logic           trig,
  output logic           flag_p_n,
  output logic           flag_m
);
  localparam int MAXC = max2(max2(max2(DLY0, DLY1), max2(DLY2, DLY3)), SETTLE_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  logic          remote;
  logic [CW-1:0] dly_len;
  logic          ld, cnt_zero, flag;
  logic [CW-1:0] ld_val;

  assign remote = ~lr_sel_n;

  always_comb begin
    unique case (dly_sel)
      2'd0:    dly_len = CW'(DLY0);
      2'd1:    dly_len = CW'(DLY1);
      2'd2:    dly_len = CW'(DLY2);
      default: dly_len = CW'(DLY3);
    endcase
  end

  rmt_func_mux #(.NFN(NFN)) u_mux (
    .clk(clk), .rst_n(rst_n), .remote(remote), .keep_panel(keep_panel),
    .panel_fn(panel_fn), .remote_fn_n(remote_fn_n),
    .fn_out(fn_out), .meter_hold(meter_hold)
  );

  rmt_dly_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_val(ld_val), .zero(cnt_zero)
  );

  rmt_flag_seq #(.CW(CW), .SETTLE_LEN(SETTLE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .remote(remote), .meas_n(meas_n),
    .dly_len(dly_len), .cnt_zero(cnt_zero), .ld(ld), .ld_val(ld_val),
    .trig(trig), .flag(flag)
  );

  assign flag_p_n = ~flag;
  assign flag_m   = flag;

  p_reset_quiet_r11: assert property (@(posedge clk)
    !rst_n |=> (!trig && !flag && !meter_hold && fn_out == '0));
endmodule

// File: tb/rmt_meas_seq_tb_top.sv
module rmt_meas_seq_tb_top;
  localparam int NFN = 4;
  localparam int D0 = 3, D1 = 6, D2 = 10, D3 = 20, ST = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lr_sel_n = 1'b1, meas_n = 1'b1, keep_panel = 1'b0;
  logic [1:0] dly_sel = 2'd0;
  logic [NFN-1:0] panel_fn = '0, remote_fn_n = '1;
  logic [NFN-1:0] fn_out;
  logic meter_hold, trig, flag_p_n, flag_m;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rmt_meas_seq #(.NFN(NFN), .DLY0(D0), .DLY1(D1), .DLY2(D2), .DLY3(D3),
                 .SETTLE_CYC(ST)) dut_i (
    .clk(clk), .rst_n(rst_n), .lr_sel_n(lr_sel_n), .meas_n(meas_n),
    .keep_panel(keep_panel), .dly_sel(dly_sel), .panel_fn(panel_fn),
    .remote_fn_n(remote_fn_n), .fn_out(fn_out), .meter_hold(meter_hold),
    .trig(trig), .flag_p_n(flag_p_n), .flag_m(flag_m)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dly_of(input int s);
    case (s)
      0: return D0;
      1: return D1;
      2: return D2;
      default: return D3;
    endcase
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk(fn_out == '0, "R11 fn_out", fn_out, 0);
    chk(!meter_hold && !trig, "R11 hold/trig", {meter_hold, trig}, 0);
    chk(flag_p_n && !flag_m, "R11 flag pair", {flag_p_n, flag_m}, 2);
    rst_n = 1'b1;
  endtask

  task automatic t_mux(input bit lr, input bit kp, input logic [3:0] pf,
                       input logic [3:0] rf, input string req);
    logic [3:0] exp;
    lr_sel_n = lr; keep_panel = kp; panel_fn = pf; remote_fn_n = rf;
    exp = (!lr && !kp) ? ~rf : pf;
    @(negedge clk);
    chk(fn_out == exp, req, fn_out, exp);
    chk(meter_hold == !lr, "R4 hold", meter_hold, !lr);
  endtask

  task automatic t_local_strobe();
    bit bad;
    bad = 1'b0;
    lr_sel_n = 1'b1; meas_n = 1'b0;
    for (int j = 0; j < ST + D3 + 5; j++) begin
      @(negedge clk);
      if (j == 3) meas_n = 1'b1;
      if (trig || flag_m || !flag_p_n) bad = 1'b1;
    end
    meas_n = 1'b1;
    chk(!bad, "R5 local strobe ignored", bad, 0);
  endtask

  // one accepted strobe; optional second strobe while busy
  task automatic t_seq(input int sel, input bit kp, input bit mid, input string req);
    int n, t_idx, c_idx, pulses;
    bit pair_ok;
    n = dly_of(sel);
    t_idx = -1; c_idx = -1; pulses = 0; pair_ok = 1'b1;
    lr_sel_n = 1'b0; keep_panel = kp; dly_sel = 2'(sel);
    @(negedge clk);
    meas_n = 1'b0;
    @(negedge clk);   // acceptance edge passed: index 0
    meas_n = 1'b1;
    dly_sel = 2'(sel + 1);
    chk(!flag_p_n && flag_m, {req, " R6 flag set"}, {flag_p_n, flag_m}, 1);
    for (int j = 1; j <= n + ST + 4; j++) begin
      @(negedge clk);
      if (mid && j == 2) meas_n = 1'b0;
      if (mid && j == n + 3) meas_n = 1'b1;
      if (flag_p_n == flag_m) pair_ok = 1'b0;
      if (trig) begin pulses++; if (t_idx < 0) t_idx = j; end
      if (flag_p_n && c_idx < 0) c_idx = j;
    end
    meas_n = 1'b1;
    chk(pair_ok, {req, " R6 complementary"}, pair_ok, 1);
    chk(t_idx == n, {req, " R7 trigger index"}, t_idx, n);
    chk(pulses == 1, {req, " R7/R10 single pulse"}, pulses, 1);
    chk(c_idx == n + ST, {req, " R8/R9 flag clear index"}, c_idx, n + ST);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_mux(1'b1, 1'b0, 4'hA, 4'h0, "R1 local A");
    t_mux(1'b1, 1'b0, 4'h5, 4'hF, "R1 local 5");
    t_mux(1'b0, 1'b0, 4'h0, 4'b0110, "R2 remote 6");
    t_mux(1'b0, 1'b0, 4'hF, 4'b1110, "R2 remote E");
    t_mux(1'b0, 1'b1, 4'h3, 4'h0, "R3 jumper remote");
    t_mux(1'b0, 1'b1, 4'hC, 4'hF, "R3 jumper remote 2");
    t_mux(1'b1, 1'b1, 4'h9, 4'h0, "R3 jumper local");
    keep_panel = 1'b0;
    t_local_strobe();
    t_seq(0, 1'b0, 1'b0, "R9 sel0");
    t_seq(1, 1'b0, 1'b0, "R7 sel1");
    t_seq(2, 1'b0, 1'b0, "R7 sel2");
    t_seq(3, 1'b0, 1'b0, "R7 sel3");
    t_seq(1, 1'b0, 1'b1, "R10 busy strobe");
    t_seq(2, 1'b1, 1'b0, "R12 jumper trigger");
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule